// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block arbitrates five interrupt sources for a small CPU core. The sources are two active-low external request pins, two timer overflow flags and one serial flag. The timers and the serial port sit outside the block and present their flags as inputs. Software programs three byte-wide registers: a mask register, a level register and an external-trigger control register. The controller samples every request line once per 12-clock machine cycle. It then picks the winning enabled request by level and by a fixed polling order.

When the core signals an instruction boundary, the controller may issue a vector. It does so only when nothing defers it and the winner may preempt whatever handler is running. The vector leaves on a valid/ready channel. `vec_valid` stays high, with `vec_addr` unchanged, until the core asserts `vec_ready` in the same cycle; that cycle is the acceptance. While `vec_valid` is high, no new vector is chosen. `in_service` reports which levels have handlers open. Each return strobe closes the highest open level.

Register map (`reg_addr`): 0 is the mask register (bit 7 global enable, bits 4:0 per-source enables). 1 is the level register (bits 4:0; 1 means high level). 2 is the trigger control register (bit 0 edge select pin 0, bit 1 request flag pin 0, bit 2 edge select pin 1, bit 3 request flag pin 1; the flag bits are read-only). Source index order, which is also the polling order, is: 0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source takes part in arbitration only when its own mask bit (register 0, bit = source index) and the global bit (register 0, bit 7) are both 1.
- R2: A pending high-level request (level bit 1) wins over any pending low-level request, whatever their polling positions.
- R3: Within one level, the lowest source index wins. Vector addresses are 0x03, 0x0B, 0x13, 0x1B and 0x23 for indices 0 to 4.
- R4: Request lines are sampled only on the clock where the machine-cycle phase is 8; the phase counts 0 to 11 from reset. A low pulse that spans no sampling clock is not seen. A low level held for 24 clocks is always seen.
- R5: In edge mode (trigger bit 1), a pin sampled high and then low at the next sample sets its request flag. The flag stays set after the pin returns high and clears when that pin's vector is accepted.
- R6: In level mode (trigger bit 0), the request flag equals the inverse of the last sampled pin value.
- R7: A high-level vector may be issued while only the low level is in service. No vector is issued for a level when that level or a higher one is in service. Acceptance sets the level's `in_service` bit (bit 0 low, bit 1 high). `reti_strobe` clears the highest set bit.
- R8: If `reti_strobe`, or a write to register 0 or 1, occurs since the previous boundary or at the boundary itself, that boundary issues no vector. The next boundary may issue one.
- R9: A vector is raised only in the cycle after an `instr_boundary` pulse. While `vec_ready` is low, `vec_valid` and `vec_addr` hold steady.
- R10: After reset, all registers read 0, `vec_valid` is low and `in_service` is 0.
- R11: Register 0 reads back bits 7 and 4:0 and returns 0 in bits 6:5. Register 1 reads back bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req_n | input | 2 | External request pins, active low |
| tmr_ovf | input | 2 | Timer overflow flags, index 0 and 1 |
| ser_irq | input | 1 | Serial port flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| instr_boundary | input | 1 | Core is between instructions |
| reti_strobe | input | 1 | Core is executing a return from interrupt |
| vec_valid | output | 1 | Vector offered to the core |
| vec_ready | input | 1 | Core accepts the vector |
| vec_addr | output | 8 | Vector address |
| in_service | output | 2 | Open handler levels, bit 1 high level |

## Verification
A wrong in-service bit would show at the very next boundary. Either a same-level vector would leak out, or a legitimate preemption would never appear. A stale edge flag would show the same way: the vector would repeat after the return strobe, or the flag bit in register 2 would stay set after acceptance. A phase-counter error would show as a missed or extra capture of a short pulse placed between two sampling clocks, visible within one machine cycle. A lost deferral would show as a vector on the first boundary after a mask write or return strobe, when none should appear until the second.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC = 5;
  localparam int IDW  = 3;

  function automatic logic [7:0] vec_of(input logic [IDW-1:0] id);
    return {2'b00, id, 3'b000} + 8'h03;
  endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int MC_CLKS   = 12,
  parameter int SAMPLE_PH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pin_n,
  input  logic [1:0] trig_edge,
  input  logic [1:0] clr,
  output logic       tick,
  output logic [1:0] flag
);
  localparam int PW = $clog2(MC_CLKS);
  localparam logic [PW-1:0] LAST = PW'(MC_CLKS - 1);
  localparam logic [PW-1:0] SPH  = PW'(SAMPLE_PH);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  assign tick = (phase == SPH);

  for (genvar p = 0; p < 2; p++) begin : g_pin
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q  <= 1'b1;
        flag[p] <= 1'b0;
      end else if (tick) begin
        prev_q <= pin_n[p];
        if (!trig_edge[p])              flag[p] <= !pin_n[p];
        else if (prev_q && !pin_n[p])   flag[p] <= 1'b1;
        else if (clr[p])                flag[p] <= 1'b0;
      end else if (clr[p]) begin
        flag[p] <= 1'b0;
      end
    end

    a_r4_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr[p]) |=> $stable(flag[p]));
    a_r5_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && clr[p]) |=> !flag[p]);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import prio_irq_pkg::*;
(
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] prio,
  output logic            any,
  output logic            lvl,
  output logic [IDW-1:0]  id
);
  logic [NSRC-1:0] hi, lo, pick;

  always_comb begin
    hi   = req & prio;
    lo   = req & ~prio;
    any  = |req;
    lvl  = |hi;
    pick = lvl ? hi : lo;
    id   = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pick[i]) id = IDW'(i);
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_lvl,
  input  logic       reti,
  output logic [1:0] ins
);
  logic [1:0] ins_nx;

  always_comb begin
    ins_nx = ins;
    if (reti) begin
      if (ins[1]) ins_nx[1] = 1'b0;
      else        ins_nx[0] = 1'b0;
    end
    if (take) ins_nx[take_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ins <= 2'b00;
    else        ins <= ins_nx;
  end

  a_r7_reti_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && (ins != 2'b00)) |=> ($countones(ins) == $countones($past(ins)) - 1));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int MC_CLKS   = 12,
  parameter int SAMPLE_PH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ext_req_n,
  input  logic [1:0] tmr_ovf,
  input  logic       ser_irq,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       instr_boundary,
  input  logic       reti_strobe,
  output logic       vec_valid,
  input  logic       vec_ready,
  output logic [7:0] vec_addr,
  output logic [1:0] in_service
);
  logic            en_glob;
  logic [NSRC-1:0] en_src, prio;
  logic [1:0]      trig;
  logic [2:0]      int_smp;
  logic [1:0]      ext_flag, clr_ext;
  logic            tick, defer_q, vec_lvl;
  logic [IDW-1:0]  vec_id;
  logic [NSRC-1:0] req_m;
  logic            win_any, win_lvl;
  logic [IDW-1:0]  win_id;
  logic            mask_wr, defer_now, allowed, issue, take;

  // register file
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_glob <= 1'b0;
      en_src  <= '0;
      prio    <= '0;
      trig    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: begin en_glob <= reg_wdata[7]; en_src <= reg_wdata[NSRC-1:0]; end
        2'd1: prio <= reg_wdata[NSRC-1:0];
        2'd2: trig <= {reg_wdata[2], reg_wdata[0]};
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {en_glob, 2'b00, en_src};
      2'd1:    reg_rdata = {3'b000, prio};
      2'd2:    reg_rdata = {4'b0000, ext_flag[1], trig[1], ext_flag[0], trig[0]};
      default: reg_rdata = 8'h00;
    endcase
  end

  irq_sampler #(.MC_CLKS(MC_CLKS), .SAMPLE_PH(SAMPLE_PH)) u_smp (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_req_n), .trig_edge(trig),
    .clr(clr_ext), .tick(tick), .flag(ext_flag)
  );

  // internal sources are sampled on the same phase as the pins
  always_ff @(posedge clk) begin
    if (!rst_n)    int_smp <= '0;
    else if (tick) int_smp <= {ser_irq, tmr_ovf[1], tmr_ovf[0]};
  end

  assign req_m = {int_smp[2], int_smp[1], ext_flag[1], int_smp[0], ext_flag[0]}
               & en_src & {NSRC{en_glob}};

  irq_arbiter u_arb (
    .req(req_m), .prio(prio), .any(win_any), .lvl(win_lvl), .id(win_id)
  );

  // deferral: return or mask/level write since the last boundary
  assign mask_wr   = reg_we && (reg_addr == 2'd0 || reg_addr == 2'd1);
  assign defer_now = defer_q || reti_strobe || mask_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)                        defer_q <= 1'b0;
    else if (instr_boundary)           defer_q <= 1'b0;
    else if (reti_strobe || mask_wr)   defer_q <= 1'b1;
  end

  assign allowed = win_lvl ? !in_service[1] : (in_service == 2'b00);
  assign issue   = instr_boundary && !defer_now && !vec_valid && win_any && allowed;
  assign take    = vec_valid && vec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_addr  <= 8'h00;
      vec_id    <= '0;
      vec_lvl   <= 1'b0;
    end else if (issue) begin
      vec_valid <= 1'b1;
      vec_addr  <= vec_of(win_id);
      vec_id    <= win_id;
      vec_lvl   <= win_lvl;
    end else if (take) begin
      vec_valid <= 1'b0;
    end
  end

  assign clr_ext = take ? ({vec_id == IDW'(2), vec_id == IDW'(0)} & trig) : 2'b00;

  irq_level_track u_lvl (
    .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(vec_lvl),
    .reti(reti_strobe), .ins(in_service)
  );

  a_r2_win_requested: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |-> req_m[win_id]);
  a_r2_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    (win_any && !win_lvl) |-> ((req_m & prio) == '0));
  a_r9_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr)));
  a_r9_only_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(instr_boundary));
  a_r7_no_same_level: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!in_service[1] && (vec_lvl || !in_service[0])));
  a_r8_deferred_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_boundary && defer_now && !vec_valid) |=> !vec_valid);
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_req_n = 2'b11;
  logic [1:0] tmr_ovf = 2'b00;
  logic       ser_irq = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       instr_boundary = 1'b0;
  logic       reti_strobe = 1'b0;
  logic       vec_valid;
  logic       vec_ready = 1'b1;
  logic [7:0] vec_addr;
  logic [1:0] in_service;

  int checks = 0;
  int failures = 0;
  int hs_cnt = 0;
  int bph = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .tmr_ovf(tmr_ovf),
    .ser_irq(ser_irq), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .instr_boundary(instr_boundary), .reti_strobe(reti_strobe),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_addr(vec_addr),
    .in_service(in_service)
  );

  // machine-cycle phase per R4: 0..11 counted from reset
  always @(posedge clk) begin
    if (!rst_n) bph <= 0;
    else        bph <= (bph == 11) ? 0 : bph + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every accepted vector is compared with the queue head
  always @(negedge clk) begin
    #1;
    if (rst_n && vec_valid && vec_ready) begin
      hs_cnt++;
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected vector", vec_addr, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(vec_addr == e, "R3 vector address", vec_addr, e);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_boundary();
    instr_boundary = 1'b1;
    @(negedge clk);
    instr_boundary = 1'b0;
  endtask

  // a mask or level write defers the next boundary (R8); consume it
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a != 2'd2) pulse_boundary();
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reti();
    reti_strobe = 1'b1;
    @(negedge clk);
    reti_strobe = 1'b0;
    pulse_boundary();
  endtask

  task automatic expect_vec(input logic [7:0] a, input string tag);
    exp_q.push_back(a);
    pulse_boundary();
    wait_clk(3);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic expect_none(input string tag);
    int h0;
    h0 = hs_cnt;
    pulse_boundary();
    wait_clk(3);
    check(hs_cnt == h0 && !vec_valid, tag, hs_cnt - h0, 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    check(1'b0, "watchdog expired", wd, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(1);

    // R10 reset state
    rd(2'd0, d); check(d == 8'h00, "R10 mask reg", d, 0);
    rd(2'd1, d); check(d == 8'h00, "R10 level reg", d, 0);
    rd(2'd2, d); check(d == 8'h00, "R10 ctrl reg", d, 0);
    check(!vec_valid && in_service == 2'b00, "R10 outputs", {vec_valid, in_service}, 0);

    // R11 read-back masking
    wr(2'd0, 8'hFF); rd(2'd0, d); check(d == 8'h9F, "R11 mask reg", d, 8'h9F);
    wr(2'd1, 8'hFF); rd(2'd1, d); check(d == 8'h1F, "R11 level reg", d, 8'h1F);
    wr(2'd1, 8'h00);

    // R1 global bit clear masks everything
    wr(2'd0, 8'h1F);
    tmr_ovf = 2'b01; wait_clk(26);
    expect_none("R1 global off");
    // R1 per-source bit clear masks its source
    wr(2'd0, 8'h88);
    expect_none("R1 source off");
    wr(2'd0, 8'h9F);
    expect_vec(8'h0B, "R1 enabled timer0");
    check(in_service == 2'b01, "R7 low level in service", in_service, 1);
    tmr_ovf = 2'b00; wait_clk(26);
    do_reti();
    check(in_service == 2'b00, "R7 reti closes", in_service, 0);

    // R3 polling order in low level
    ext_req_n = 2'b10; tmr_ovf = 2'b10; ser_irq = 1'b1; wait_clk(26);
    expect_vec(8'h03, "R3 ext0 first");
    ext_req_n = 2'b11; tmr_ovf = 2'b00; ser_irq = 1'b0; wait_clk(26);
    do_reti();
    tmr_ovf = 2'b10; ser_irq = 1'b1; wait_clk(26);
    expect_vec(8'h1B, "R3 timer1 before serial");
    tmr_ovf = 2'b00; ser_irq = 1'b0; wait_clk(26);
    do_reti();

    // R2 high level beats earlier poll position
    wr(2'd1, 8'h10);
    tmr_ovf = 2'b01; ser_irq = 1'b1; wait_clk(26);
    expect_vec(8'h23, "R2 serial high level");
    check(in_service == 2'b10, "R7 high level in service", in_service, 2);
    tmr_ovf = 2'b00; ser_irq = 1'b0; wait_clk(26);
    do_reti();
    wr(2'd1, 8'h00);

    // R7 preemption rules
    tmr_ovf = 2'b01; wait_clk(26);
    expect_vec(8'h0B, "R7 low handler");
    ext_req_n = 2'b01; wait_clk(26);
    expect_none("R7 same level blocked");
    wr(2'd1, 8'h10);
    ser_irq = 1'b1; wait_clk(26);
    expect_vec(8'h23, "R7 high preempts low");
    check(in_service == 2'b11, "R7 both open", in_service, 3);
    ser_irq = 1'b0; wait_clk(26);
    do_reti();
    check(in_service == 2'b01, "R7 reti pops high first", in_service, 1);
    ext_req_n = 2'b11; tmr_ovf = 2'b00; wait_clk(26);
    do_reti();
    check(in_service == 2'b00, "R7 reti pops low", in_service, 0);
    wr(2'd1, 8'h00);

    // R8 deferral by mask write
    tmr_ovf = 2'b10; wait_clk(26);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h9F;
    @(negedge clk);
    reg_we = 1'b0;
    expect_none("R8 mask write defers");
    expect_vec(8'h1B, "R8 next boundary serves");
    tmr_ovf = 2'b00; wait_clk(26);
    do_reti();
    // R8 deferral by return strobe
    tmr_ovf = 2'b01; wait_clk(26);
    reti_strobe = 1'b1;
    @(negedge clk);
    reti_strobe = 1'b0;
    expect_none("R8 reti defers");
    expect_vec(8'h0B, "R8 served after reti");
    tmr_ovf = 2'b00; wait_clk(26);
    do_reti();

    // R4 short pulse between sampling clocks is missed
    while (bph != 9) @(negedge clk);
    ext_req_n = 2'b10; wait_clk(10);
    ext_req_n = 2'b11; wait_clk(1);
    rd(2'd2, d); check(d[1] == 1'b0, "R4 short pulse flag", d, 0);
    wait_clk(14);
    expect_none("R4 short pulse no vector");
    // R4 low held 24 clocks is captured
    ext_req_n = 2'b10; wait_clk(24);
    expect_vec(8'h03, "R4 long low captured");
    ext_req_n = 2'b11; wait_clk(26);
    do_reti();

    // R6 level mode flag follows pin
    ext_req_n = 2'b10; wait_clk(14);
    rd(2'd2, d); check(d[1] == 1'b1, "R6 flag set while low", d, 2);
    ext_req_n = 2'b11; wait_clk(14);
    rd(2'd2, d); check(d[1] == 1'b0, "R6 flag clear when high", d, 0);

    // R5 edge mode on pin 1
    wr(2'd2, 8'h04);
    ext_req_n = 2'b01; wait_clk(14);
    ext_req_n = 2'b11; wait_clk(14);
    rd(2'd2, d); check(d[3] == 1'b1, "R5 edge flag latched", d, 8'h0C);
    expect_vec(8'h13, "R5 edge vector");
    rd(2'd2, d); check(d[3] == 1'b0, "R5 flag cleared on accept", d, 8'h04);
    do_reti();
    wr(2'd2, 8'h00);

    // R9 back-pressure and boundary-only issue
    vec_ready = 1'b0;
    tmr_ovf = 2'b01; wait_clk(26);
    check(!vec_valid, "R9 no vector without boundary", vec_valid, 0);
    pulse_boundary();
    wait_clk(5);
    check(vec_valid && vec_addr == 8'h0B, "R9 held under back-pressure", vec_addr, 8'h0B);
    exp_q.push_back(8'h0B);
    vec_ready = 1'b1;
    wait_clk(3);
    check(exp_q.size() == 0 && !vec_valid, "R9 accepted after ready", exp_q.size(), 0);
    tmr_ovf = 2'b00; wait_clk(26);
    do_reti();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule